// File: doc/BRIEF.md
# Reed-Solomon Decoder Status and Write Control

This block follows a group of multichannel Reed-Solomon decoders that run in lockstep. Each decoder emits a stream of byte-interleaved codewords, one symbol from each channel in turn. The block turns the decoders' framing pulses into a FIFO write enable, so that only corrected information symbols are kept and the trailing check symbols are dropped. It also gathers error statistics for each codeword. The reported error counts are latched into a holding register whenever a decoder reports errors. A sticky fail flag acts as an interrupt. Every corrected symbol is located by comparing the decoder's delayed input with its corrected output.

Within a codeword, the cycle count since the start of the block-start pulse is called the slot. The symbol index is the slot divided by the channel count, and the channel index is the slot modulo the channel count. Block-start covers symbol 0 of every channel, so it is as many cycles long as there are channels. Information-end covers symbol K-1 in the same way. With the default code of 255 symbols carrying 239 information symbols, each channel has 16 check symbols. Every count field is therefore 5 bits wide, enough to hold 0 to 16.

Top module: `rs_dec_status`

## Requirements
- R1: `fifo_wdata` carries the corrected data of all decoders, delayed by one cycle, with decoder d in bits [d*SYM_W +: SYM_W].
- R2: `fifo_we` is high one cycle after each slot of symbol index 0 to K_SYM-1 and is low for every check-symbol slot and every cycle outside a codeword.
- R3: On a block-start cycle, if any decoder raises error-found and no decoder raises fail, `err_cnt_hold` loads all count fields on the next cycle. Decoder d sits in bits [d*CNT_W +: CNT_W], and each field is CNT_W = clog2(N_SYM-K_SYM+1) bits wide.
- R4: A fail from any decoder on a block-start cycle sets `fail_irq` on the next cycle, and `err_cnt_hold` keeps its value for that cycle's sample.
- R5: `fail_irq` stays set until a cycle with `fail_clr` high. Clearing happens on the next cycle, except when a new fail arrives in the same cycle, in which case the flag stays set.
- R6: An error record reports the symbol index (slot / NUM_CH, 0 to N_SYM-1) and the channel index (slot mod NUM_CH) of the symbol it describes.
- R7: For each decoder, a nonzero XOR of delayed input and corrected output inside a codeword gives a one-cycle `epos_vld[d]` strobe on the next cycle, with `epos_pat` bits [d*SYM_W +: SYM_W] equal to that XOR. A zero XOR gives no strobe.
- R8: Outside a codeword (after the last slot and before the next block-start) a nonzero XOR gives no strobe and no FIFO write.
- R9: During reset, `fifo_we`, `fifo_wdata`, `err_cnt_hold`, `fail_irq` and `epos_vld` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_blk_start | input | NUM_DEC | Block-start pulse per decoder |
| dec_info_end | input | NUM_DEC | Last-information-symbol pulse per decoder |
| dec_data | input | NUM_DEC*SYM_W | Corrected symbols |
| dec_data_dly | input | NUM_DEC*SYM_W | Delayed uncorrected symbols |
| dec_err_cnt | input | NUM_DEC*CNT_W | Error count per decoder |
| dec_err_found | input | NUM_DEC | Error-found flag per decoder |
| dec_fail | input | NUM_DEC | Uncorrectable flag per decoder |
| fail_clr | input | 1 | Write-one-to-clear for the fail flag |
| fifo_we | output | 1 | FIFO write enable |
| fifo_wdata | output | NUM_DEC*SYM_W | FIFO write data |
| err_cnt_hold | output | NUM_DEC*CNT_W | Latched error counts |
| fail_irq | output | 1 | Sticky fail interrupt |
| epos_vld | output | NUM_DEC | Error record strobe per decoder |
| epos_sym | output | SIDX_W | Symbol index of the record |
| epos_ch | output | CIDX_W | Channel index of the record |
| epos_pat | output | NUM_DEC*SYM_W | Error pattern per decoder |

## Verification
The assertions assume that the decoders stay aligned. Block-start must be high for exactly the NUM_CH slots of symbol 0, and only there. Information-end must cover only the slots of symbol K_SYM-1. Status inputs are meaningful only while block-start is high. The stimulus builds every codeword from a slot counter, so these pulses always land on those slots. Between codewords it inserts idle gaps whose delayed data deliberately differs from the corrected data. It uses a channel count of three, which is not a power of two, so the modulo position arithmetic is exercised.

// File: rtl/rsst_pkg.sv
package rsst_pkg;

  // width that can represent 0 .. (n-k)
  function automatic int unsigned cnt_width(input int unsigned n, input int unsigned k);
    return $clog2(n - k + 1);
  endfunction

  // increment with wrap at lim
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // difference between received and corrected symbol
  function automatic logic [31:0] sym_delta(input logic [31:0] corr, input logic [31:0] rcv);
    return corr ^ rcv;
  endfunction

endpackage

// File: rtl/rsst_pos_track.sv
module rsst_pos_track #(
  parameter int NUM_CH = 8,
  parameter int N_SYM  = 255,
  parameter int SIDX_W = 8,
  parameter int CIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_any,
  output logic              cur_run,
  output logic [SIDX_W-1:0] cur_sym,
  output logic [CIDX_W-1:0] cur_ch
);
  logic              start_d;
  logic              run_q;
  logic [SIDX_W-1:0] sym_q;
  logic [CIDX_W-1:0] ch_q;
  logic              start_rise;

  assign start_rise = start_any & ~start_d;

  always_comb begin
    cur_run = 1'b0;
    cur_sym = '0;
    cur_ch  = '0;
    if (start_rise) begin
      cur_run = 1'b1;
    end else if (run_q) begin
      cur_run = 1'b1;
      cur_ch  = CIDX_W'(rsst_pkg::wrap_inc(32'(ch_q), NUM_CH));
      cur_sym = sym_q;
      if (32'(ch_q) == NUM_CH - 1) begin
        if (32'(sym_q) == N_SYM - 1) cur_run = 1'b0;
        else cur_sym = SIDX_W'(rsst_pkg::wrap_inc(32'(sym_q), N_SYM));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_d <= 1'b0;
      run_q   <= 1'b0;
      sym_q   <= '0;
      ch_q    <= '0;
    end else begin
      start_d <= start_any;
      run_q   <= cur_run;
      sym_q   <= cur_sym;
      ch_q    <= cur_ch;
    end
  end

  assert_pos_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_run |-> (32'(cur_ch) < NUM_CH) && (32'(cur_sym) < N_SYM));

  assert_start_sym0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_any && cur_run) |-> (cur_sym == '0));

endmodule

// File: rtl/rsst_wr_gate.sv
module rsst_wr_gate #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_any,
  input  logic          end_any,
  input  logic [DW-1:0] data_in,
  output logic          fifo_we,
  output logic [DW-1:0] fifo_wdata
);
  logic in_info_q;
  logic capture;

  assign capture = start_any | end_any | in_info_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_info_q  <= 1'b0;
      fifo_we    <= 1'b0;
      fifo_wdata <= '0;
    end else begin
      if (start_any)    in_info_q <= 1'b1;
      else if (end_any) in_info_q <= 1'b0;
      fifo_we    <= capture;
      fifo_wdata <= data_in;
    end
  end

  assert_we_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_we) |-> $past(start_any));

  assert_we_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(end_any) && !start_any) |=> !fifo_we);

  assert_data_pipe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fifo_wdata == $past(data_in)));

endmodule

// File: rtl/rsst_err_stat.sv
module rsst_err_stat #(
  parameter int NUM_DEC = 2,
  parameter int CNT_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample,
  input  logic [NUM_DEC-1:0]       err_found,
  input  logic [NUM_DEC-1:0]       fail,
  input  logic [NUM_DEC*CNT_W-1:0] err_cnt,
  input  logic                     fail_clr,
  output logic [NUM_DEC*CNT_W-1:0] cnt_hold,
  output logic                     fail_flag
);
  logic any_found;
  logic any_fail;

  assign any_found = sample & (|err_found);
  assign any_fail  = sample & (|fail);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_hold  <= '0;
      fail_flag <= 1'b0;
    end else begin
      if (any_found && !any_fail) cnt_hold <= err_cnt;
      if (any_fail)      fail_flag <= 1'b1;
      else if (fail_clr) fail_flag <= 1'b0;
    end
  end

  assert_fail_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_fail |=> fail_flag);

  assert_fail_holds_cnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_fail |=> $stable(cnt_hold));

  assert_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_clr && !any_fail) |=> !fail_flag);

  assert_cnt_only_on_found_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_found |=> $stable(cnt_hold));

endmodule

// File: rtl/rsst_err_loc.sv
module rsst_err_loc #(
  parameter int NUM_DEC = 2,
  parameter int SYM_W   = 8,
  parameter int SIDX_W  = 8,
  parameter int CIDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_DEC*SYM_W-1:0] data_corr,
  input  logic [NUM_DEC*SYM_W-1:0] data_rcv,
  input  logic                     cur_run,
  input  logic [SIDX_W-1:0]        cur_sym,
  input  logic [CIDX_W-1:0]        cur_ch,
  output logic [NUM_DEC-1:0]       rec_vld,
  output logic [SIDX_W-1:0]        rec_sym,
  output logic [CIDX_W-1:0]        rec_ch,
  output logic [NUM_DEC*SYM_W-1:0] rec_pat
);
  logic run_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_sym <= '0;
      rec_ch  <= '0;
      run_d   <= 1'b0;
    end else begin
      rec_sym <= cur_sym;
      rec_ch  <= cur_ch;
      run_d   <= cur_run;
    end
  end

  for (genvar d = 0; d < NUM_DEC; d++) begin : g_dec
    logic [SYM_W-1:0] delta;
    assign delta = SYM_W'(rsst_pkg::sym_delta(32'(data_corr[d*SYM_W +: SYM_W]),
                                              32'(data_rcv[d*SYM_W +: SYM_W])));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rec_vld[d]                 <= 1'b0;
        rec_pat[d*SYM_W +: SYM_W]  <= '0;
      end else begin
        rec_vld[d]                 <= cur_run && (delta != '0);
        rec_pat[d*SYM_W +: SYM_W]  <= delta;
      end
    end

    assert_rec_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rec_vld[d] |-> (rec_pat[d*SYM_W +: SYM_W] != '0));

    assert_rec_in_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rec_vld[d] |-> run_d);
  end

endmodule

// File: rtl/rs_dec_status.sv
module rs_dec_status #(
  parameter int NUM_DEC = 2,
  parameter int NUM_CH  = 8,
  parameter int SYM_W   = 8,
  parameter int N_SYM   = 255,
  parameter int K_SYM   = 239,
  parameter int CNT_W   = rsst_pkg::cnt_width(N_SYM, K_SYM),
  parameter int SIDX_W  = $clog2(N_SYM),
  parameter int CIDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_DEC-1:0]       dec_blk_start,
  input  logic [NUM_DEC-1:0]       dec_info_end,
  input  logic [NUM_DEC*SYM_W-1:0] dec_data,
  input  logic [NUM_DEC*SYM_W-1:0] dec_data_dly,
  input  logic [NUM_DEC*CNT_W-1:0] dec_err_cnt,
  input  logic [NUM_DEC-1:0]       dec_err_found,
  input  logic [NUM_DEC-1:0]       dec_fail,
  input  logic                     fail_clr,
  output logic                     fifo_we,
  output logic [NUM_DEC*SYM_W-1:0] fifo_wdata,
  output logic [NUM_DEC*CNT_W-1:0] err_cnt_hold,
  output logic                     fail_irq,
  output logic [NUM_DEC-1:0]       epos_vld,
  output logic [SIDX_W-1:0]        epos_sym,
  output logic [CIDX_W-1:0]        epos_ch,
  output logic [NUM_DEC*SYM_W-1:0] epos_pat
);
  localparam int DW = NUM_DEC * SYM_W;

  logic              start_any;
  logic              end_any;
  logic              cur_run;
  logic [SIDX_W-1:0] cur_sym;
  logic [CIDX_W-1:0] cur_ch;

  assign start_any = |dec_blk_start;
  assign end_any   = |dec_info_end;

  rsst_pos_track #(.NUM_CH(NUM_CH), .N_SYM(N_SYM), .SIDX_W(SIDX_W), .CIDX_W(CIDX_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .start_any(start_any),
    .cur_run(cur_run), .cur_sym(cur_sym), .cur_ch(cur_ch));

  rsst_wr_gate #(.DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .start_any(start_any), .end_any(end_any),
    .data_in(dec_data), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata));

  rsst_err_stat #(.NUM_DEC(NUM_DEC), .CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .sample(start_any), .err_found(dec_err_found),
    .fail(dec_fail), .err_cnt(dec_err_cnt), .fail_clr(fail_clr),
    .cnt_hold(err_cnt_hold), .fail_flag(fail_irq));

  rsst_err_loc #(.NUM_DEC(NUM_DEC), .SYM_W(SYM_W), .SIDX_W(SIDX_W), .CIDX_W(CIDX_W)) u_loc (
    .clk(clk), .rst_n(rst_n), .data_corr(dec_data), .data_rcv(dec_data_dly),
    .cur_run(cur_run), .cur_sym(cur_sym), .cur_ch(cur_ch),
    .rec_vld(epos_vld), .rec_sym(epos_sym), .rec_ch(epos_ch), .rec_pat(epos_pat));

  assert_no_write_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_run && !start_any && !end_any) |=> !fifo_we || $past(fifo_we));

endmodule

// File: tb/rs_dec_status_tb_top.sv
module rs_dec_status_tb_top;
  localparam int CLK_T = 10;
  localparam int ND  = 2;
  localparam int NCH = 3;
  localparam int SW  = 8;
  localparam int N   = 255;
  localparam int K   = 239;
  localparam int CW  = 5;
  localparam int SIW = 8;
  localparam int CHW = 2;
  localparam int NBLK = 6;
  localparam int GAP  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ND-1:0]    blk_start = '0, info_end = '0, err_found = '0, fail = '0;
  logic [ND*SW-1:0] data = '0, data_dly = '0;
  logic [ND*CW-1:0] err_cnt = '0;
  logic             fail_clr = 1'b0;
  logic             fifo_we, fail_irq;
  logic [ND*SW-1:0] fifo_wdata, epos_pat;
  logic [ND*CW-1:0] err_cnt_hold;
  logic [ND-1:0]    epos_vld;
  logic [SIW-1:0]   epos_sym;
  logic [CHW-1:0]   epos_ch;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  rs_dec_status #(.NUM_DEC(ND), .NUM_CH(NCH), .SYM_W(SW), .N_SYM(N), .K_SYM(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .dec_blk_start(blk_start), .dec_info_end(info_end),
    .dec_data(data), .dec_data_dly(data_dly), .dec_err_cnt(err_cnt),
    .dec_err_found(err_found), .dec_fail(fail), .fail_clr(fail_clr),
    .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .err_cnt_hold(err_cnt_hold),
    .fail_irq(fail_irq), .epos_vld(epos_vld), .epos_sym(epos_sym),
    .epos_ch(epos_ch), .epos_pat(epos_pat));

  logic             e_we = 0, e_fail = 0;
  logic [ND*SW-1:0] e_data = '0, e_pat = '0;
  logic [ND*CW-1:0] e_cnt = '0;
  logic [ND-1:0]    e_vld = '0;
  int               e_sym = 0, e_ch = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  function automatic int dat_of(int b, int s, int d);
    return (b*53 + s*11 + d*97 + 5) % 256;
  endfunction

  function automatic int pat_of(int b, int s, int d);
    if (((s*7 + b*3 + d*5) % 29) == 0) return ((s + b*13 + d) % 255) + 1;
    return 0;
  endfunction

  task automatic check_outputs();
    chk(fifo_we == e_we, "R2", "fifo_we", fifo_we, e_we);
    if (e_we) chk(fifo_wdata == e_data, "R1", "fifo_wdata", fifo_wdata, e_data);
    chk(err_cnt_hold == e_cnt, "R3", "err_cnt_hold", err_cnt_hold, e_cnt);
    chk(fail_irq == e_fail, "R4/R5", "fail_irq", fail_irq, e_fail);
    for (int d = 0; d < ND; d++) begin
      chk(epos_vld[d] == e_vld[d], e_vld[d] ? "R7" : "R8", "epos_vld", epos_vld[d], e_vld[d]);
      if (e_vld[d]) begin
        chk(epos_pat[d*SW +: SW] == e_pat[d*SW +: SW], "R7", "epos_pat",
            epos_pat[d*SW +: SW], e_pat[d*SW +: SW]);
        chk(int'(epos_sym) == e_sym, "R6", "epos_sym", epos_sym, e_sym);
        chk(int'(epos_ch) == e_ch, "R6", "epos_ch", epos_ch, e_ch);
      end
    end
  endtask

  // apply one cycle of stimulus and compute the expected outputs one cycle later
  task automatic apply(input int b, input int s, input bit inblk);
    bit st, en, any_f, any_fail, clr;
    int sym, ch;
    sym = s / NCH;
    ch  = s % NCH;
    st  = inblk && (sym == 0);
    en  = inblk && (sym == K-1);
    clr = (b == 4 && s == 20) || (b == 3 && s == 1);
    blk_start = {ND{st}};
    info_end  = {ND{en}};
    fail_clr  = clr;
    any_f = 0; any_fail = 0;
    for (int d = 0; d < ND; d++) begin
      int v, p;
      v = dat_of(b, s, d);
      p = inblk ? pat_of(b, s, d) : 8'hA5;
      data[d*SW +: SW]     = SW'(v);
      data_dly[d*SW +: SW] = SW'(v ^ p);
      err_found[d]         = st && (b % 3 != 0);
      fail[d]              = st && b == 3 && d == 1 && s == 1;
      err_cnt[d*CW +: CW]  = st ? CW'((b + s + d) % 17) : '0;
      any_f    |= err_found[d];
      any_fail |= fail[d];
      e_vld[d] = inblk && (p != 0);
      e_pat[d*SW +: SW] = SW'(p);
    end
    e_we   = inblk && (s < K*NCH);
    e_data = data;
    e_sym  = sym;
    e_ch   = ch;
    if (any_f && !any_fail) e_cnt = err_cnt;
    if (any_fail) e_fail = 1'b1;
    else if (clr) e_fail = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(fifo_we == 0, "R9", "fifo_we", fifo_we, 0);
    chk(fifo_wdata == 0, "R9", "fifo_wdata", fifo_wdata, 0);
    chk(err_cnt_hold == 0, "R9", "err_cnt_hold", err_cnt_hold, 0);
    chk(fail_irq == 0, "R9", "fail_irq", fail_irq, 0);
    chk(epos_vld == 0, "R9", "epos_vld", epos_vld, 0);
    rst_n = 1'b1;
    for (int b = 0; b < NBLK; b++) begin
      for (int g = 0; g < GAP; g++) begin
        @(negedge clk);
        check_outputs();
        apply(b, g, 1'b0);
      end
      for (int s = 0; s < N*NCH; s++) begin
        @(negedge clk);
        check_outputs();
        apply(b, s, 1'b1);
      end
    end
    @(negedge clk);
    check_outputs();
    apply(NBLK, 0, 1'b0);
    @(negedge clk);
    check_outputs();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_T * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule